// File: doc/BRIEF.md
# Command-Addressed I2C Sensor Register Interface

This block is the serial front end of a light-sensor core. It listens on a two-wire I2C bus as a target with a fixed 7-bit address. It gives a host controller read and write access to a small register file that holds the sensor's configuration, identity, status and the latest two-channel conversion result. The sensor core pushes finished conversions into the block and raises interrupt events. The block turns the configuration registers into plain output pins for that core.

The first byte a host writes after the address is treated as a command when its top bit is set. A command either loads the register pointer and selects an access mode, or it performs a special function. In repeat mode, every following data byte reads or writes the same register. In increment mode, the pointer advances after each byte and wraps within the 5-bit address space. One special function clears the pending interrupt. Reading the low byte of a channel result saves that channel's high byte in a shadow register, so the two bytes of a 16-bit reading always belong together.

The result input is a valid/ready stream. Ready is held high at all times, so no back-pressure is ever applied. A result is taken in every cycle where valid is high, and a later result overwrites an earlier one.

Top module: `i2c_cmd_regif`

## Requirements
- R1: The block acknowledges an address byte whose upper 7 bits equal 0x39 (ALT_ADDR=0) or 0x29 (ALT_ADDR=1). On any other address it leaves SDA released for the address acknowledge and for every later bit until the next start.
- R2: A falling SDA while SCL is high is a start, and it is also a repeated start. A rising SDA while SCL is high is a stop. Both reset the byte engine and release SDA.
- R3: In a write, the first data byte with bit 7 set is a command. Its bits 6:5 give the type and bits 4:0 give the pointer. Type 00 (repeat) keeps the pointer fixed for later bytes. Type 01 (increment) adds one to the pointer after every data byte written or read.
- R4: Type 11 with code 5'b00110 clears the pending interrupt. Type 11 with code 5'b00000 has no effect. Type 10 is ignored. No type 11 or type 10 command changes the pointer or the mode.
- R5: A written byte that is not a command is stored at the current pointer. A read that has no command before it uses the pointer left by earlier traffic.
- R6: After reset the registers hold these values: 0x00 enable=0x00, 0x01 integration time=0xFF, 0x03 wait time=0xFF, 0x04–0x07 thresholds=0x00, 0x0C persistence=0x00, 0x0D config=0x00, 0x0F control=0x00, 0x13 status=0x00.
- R7: Writes to the read-only addresses 0x12 (ID, reads DEV_ID, default 0x04), 0x13 and 0x14–0x17 are ignored. A read of an unimplemented address returns 0x00.
- R8: A read of 0x14 (channel 0 low) or 0x16 (channel 1 low) copies that channel's high byte into its shadow. A read of 0x15 or 0x17 returns the shadow, even if a new result arrived in between.
- R9: In increment mode, pointer 0x1F is followed by 0x00.
- R10: res_ready is always 1. Each cycle with res_valid high stores both 16-bit channel values. These read back little-endian at 0x14–0x17, and status bit 0 is set.
- R11: A pulse on int_raise sets int_pending, which reads as status bit 4. If int_raise and a clear arrive in the same cycle, the raise wins.
- R12: SDA is driven only as an open-drain low enable. The enable changes only while SCL is low, except on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When high, pull SDA low |
| res_valid | input | 1 | New conversion result present |
| res_ready | output | 1 | Always 1, result accepted |
| res_ch0 | input | 16 | Channel 0 result |
| res_ch1 | input | 16 | Channel 1 result |
| int_raise | input | 1 | Interrupt event from the sensor core |
| int_pending | output | 1 | Interrupt pending flag |
| enable_o | output | 8 | Enable register (0x00) |
| atime_o | output | 8 | Integration time register (0x01) |
| wtime_o | output | 8 | Wait time register (0x03) |
| thr_lo_o | output | 16 | Low threshold {0x05,0x04} |
| thr_hi_o | output | 16 | High threshold {0x07,0x06} |
| pers_o | output | 8 | Persistence register (0x0C) |
| config_o | output | 8 | Config register (0x0D) |
| control_o | output | 8 | Control register (0x0F) |

## Verification
The hardest case to reach is a torn 16-bit read. It needs the low byte read, then a fresh result, then the high byte read. The stimulus reaches it with two separate transactions in repeat mode. The first reads 0x14 alone, a new result is pushed between the transactions, and the second reads 0x15. The shadow must give the old high byte, and a third read of 0x14 must give the new low byte. Other tests check that the special-function and reserved commands leave the pointer unchanged, by doing a read with no command right after them.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } link_state_t;

  localparam int PTR_W = 5;

  localparam logic [1:0] CT_REPEAT  = 2'b00;
  localparam logic [1:0] CT_INCR    = 2'b01;
  localparam logic [1:0] CT_RSVD    = 2'b10;
  localparam logic [1:0] CT_SPECIAL = 2'b11;

  localparam logic [PTR_W-1:0] SF_NOP     = 5'b00000;
  localparam logic [PTR_W-1:0] SF_INT_CLR = 5'b00110;

  localparam logic [PTR_W-1:0] A_ENABLE  = 5'h00;
  localparam logic [PTR_W-1:0] A_ATIME   = 5'h01;
  localparam logic [PTR_W-1:0] A_WTIME   = 5'h03;
  localparam logic [PTR_W-1:0] A_THL_LO  = 5'h04;
  localparam logic [PTR_W-1:0] A_THL_HI  = 5'h05;
  localparam logic [PTR_W-1:0] A_THH_LO  = 5'h06;
  localparam logic [PTR_W-1:0] A_THH_HI  = 5'h07;
  localparam logic [PTR_W-1:0] A_PERS    = 5'h0C;
  localparam logic [PTR_W-1:0] A_CONFIG  = 5'h0D;
  localparam logic [PTR_W-1:0] A_CONTROL = 5'h0F;
  localparam logic [PTR_W-1:0] A_ID      = 5'h12;
  localparam logic [PTR_W-1:0] A_STATUS  = 5'h13;
  localparam logic [PTR_W-1:0] A_C0_LO   = 5'h14;
  localparam logic [PTR_W-1:0] A_C0_HI   = 5'h15;
  localparam logic [PTR_W-1:0] A_C1_LO   = 5'h16;
  localparam logic [PTR_W-1:0] A_C1_HI   = 5'h17;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_d;
  logic                   sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_link_engine.sv
module i2c_link_engine
  import i2c_regif_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       wr_first,
  output logic       rd_take
);

  link_state_t state;
  logic [7:0]  shreg;
  logic [7:0]  txreg;
  logic [2:0]  cnt;
  logic        ack_on;
  logic        is_read;
  logic        first_q;
  logic        mack;
  logic [7:0]  nxt;

  assign nxt = {shreg[6:0], sda_s};

  // A byte is fetched when the address acknowledge ends on a read, or
  // when the host has acknowledged the previous byte.
  always_comb begin
    rd_take = 1'b0;
    if (!start_det && !stop_det && scl_fall) begin
      if (state == ST_ADDR_ACK && ack_on && is_read) rd_take = 1'b1;
      if (state == ST_RD_ACK && !mack)               rd_take = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      txreg    <= '0;
      cnt      <= '0;
      sda_oe   <= 1'b0;
      ack_on   <= 1'b0;
      is_read  <= 1'b0;
      first_q  <= 1'b0;
      mack     <= 1'b1;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_first <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        ack_on  <= 1'b0;
        first_q <= 1'b1;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            shreg <= nxt;
            if (cnt == 3'd7) begin
              cnt <= '0;
              if (nxt[7:1] == TARGET_ADDR) begin
                is_read <= nxt[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              cnt    <= '0;
              if (is_read) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            shreg <= nxt;
            if (cnt == 3'd7) begin
              cnt      <= '0;
              wr_valid <= 1'b1;
              wr_data  <= nxt;
              wr_first <= first_q;
              first_q  <= 1'b0;
              state    <= ST_WR_ACK;
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
              cnt    <= cnt + 3'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) mack <= sda_s;
            if (scl_fall) begin
              if (!mack) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_sensor_regs.sv
module i2c_sensor_regs
  import i2c_regif_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h04,
  parameter int         RES_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_first,
  input  logic             rd_take,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_ch0,
  input  logic [RES_W-1:0] res_ch1,
  input  logic             int_raise,
  output logic [7:0]       rd_data,
  output logic             int_pending,
  output logic             int_clr,
  output logic [PTR_W-1:0] ptr_q,
  output logic             incr_q,
  output logic             ptr_step,
  output logic [7:0]       enable_o,
  output logic [7:0]       atime_o,
  output logic [7:0]       wtime_o,
  output logic [15:0]      thr_lo_o,
  output logic [15:0]      thr_hi_o,
  output logic [7:0]       pers_o,
  output logic [7:0]       config_o,
  output logic [7:0]       control_o
);

  localparam int NCH = 2;

  logic             is_cmd;
  logic [1:0]       cmd_type;
  logic [PTR_W-1:0] cmd_code;
  logic             data_wr;
  logic             valid_q;
  logic [15:0]      ch_q   [NCH];
  logic [7:0]       shadow [NCH];
  logic [RES_W-1:0] res_in [NCH];

  assign res_in[0] = res_ch0;
  assign res_in[1] = res_ch1;

  assign is_cmd   = wr_valid & wr_first & wr_data[7];
  assign cmd_type = wr_data[6:5];
  assign cmd_code = wr_data[4:0];
  assign int_clr  = is_cmd && (cmd_type == CT_SPECIAL) && (cmd_code == SF_INT_CLR);
  assign data_wr  = wr_valid & ~is_cmd;
  assign ptr_step = (data_wr | rd_take) & incr_q;

  // Pointer and access mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else if (is_cmd) begin
      if (cmd_type == CT_REPEAT || cmd_type == CT_INCR) begin
        ptr_q  <= cmd_code;
        incr_q <= (cmd_type == CT_INCR);
      end
    end else if (ptr_step) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // Writable configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o  <= 8'h00;
      atime_o   <= 8'hFF;
      wtime_o   <= 8'hFF;
      thr_lo_o  <= 16'h0000;
      thr_hi_o  <= 16'h0000;
      pers_o    <= 8'h00;
      config_o  <= 8'h00;
      control_o <= 8'h00;
    end else if (data_wr) begin
      unique case (ptr_q)
        A_ENABLE:  enable_o        <= wr_data;
        A_ATIME:   atime_o         <= wr_data;
        A_WTIME:   wtime_o         <= wr_data;
        A_THL_LO:  thr_lo_o[7:0]   <= wr_data;
        A_THL_HI:  thr_lo_o[15:8]  <= wr_data;
        A_THH_LO:  thr_hi_o[7:0]   <= wr_data;
        A_THH_HI:  thr_hi_o[15:8]  <= wr_data;
        A_PERS:    pers_o          <= wr_data;
        A_CONFIG:  config_o        <= wr_data;
        A_CONTROL: control_o       <= wr_data;
        default: ;
      endcase
    end
  end

  // Interrupt flag: a raise beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         int_pending <= 1'b0;
    else if (int_raise) int_pending <= 1'b1;
    else if (int_clr)   int_pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (res_valid) valid_q <= 1'b1;
  end

  // Per-channel result capture and high-byte shadow
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [PTR_W-1:0] LO_ADDR = A_C0_LO + PTR_W'(2 * c);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ch_q[c]   <= '0;
          shadow[c] <= '0;
        end else begin
          if (res_valid) ch_q[c] <= 16'(res_in[c]);
          if (rd_take && ptr_q == LO_ADDR) shadow[c] <= ch_q[c][15:8];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (ptr_q)
      A_ENABLE:  rd_data = enable_o;
      A_ATIME:   rd_data = atime_o;
      A_WTIME:   rd_data = wtime_o;
      A_THL_LO:  rd_data = thr_lo_o[7:0];
      A_THL_HI:  rd_data = thr_lo_o[15:8];
      A_THH_LO:  rd_data = thr_hi_o[7:0];
      A_THH_HI:  rd_data = thr_hi_o[15:8];
      A_PERS:    rd_data = pers_o;
      A_CONFIG:  rd_data = config_o;
      A_CONTROL: rd_data = control_o;
      A_ID:      rd_data = DEV_ID;
      A_STATUS:  rd_data = {3'b000, int_pending, 3'b000, valid_q};
      A_C0_LO:   rd_data = ch_q[0][7:0];
      A_C0_HI:   rd_data = shadow[0];
      A_C1_LO:   rd_data = ch_q[1][7:0];
      A_C1_HI:   rd_data = shadow[1];
      default:   rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif
  import i2c_regif_pkg::*;
#(
  parameter bit         ALT_ADDR    = 1'b0,
  parameter logic [7:0] DEV_ID      = 8'h04,
  parameter int         SYNC_STAGES = 2,
  parameter int         RES_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_ch0,
  input  logic [RES_W-1:0] res_ch1,
  input  logic             int_raise,
  output logic             int_pending,
  output logic [7:0]       enable_o,
  output logic [7:0]       atime_o,
  output logic [7:0]       wtime_o,
  output logic [15:0]      thr_lo_o,
  output logic [15:0]      thr_hi_o,
  output logic [7:0]       pers_o,
  output logic [7:0]       config_o,
  output logic [7:0]       control_o
);

  localparam logic [6:0] TARGET_ADDR = ALT_ADDR ? 7'h29 : 7'h39;

  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]       rd_data, wr_data;
  logic             wr_valid, wr_first, rd_take;
  logic             int_clr, incr_q, ptr_step;
  logic [PTR_W-1:0] ptr_q;

  assign res_ready = 1'b1;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_link_engine #(.TARGET_ADDR(TARGET_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_first(wr_first), .rd_take(rd_take)
  );

  i2c_sensor_regs #(.DEV_ID(DEV_ID), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_first(wr_first), .rd_take(rd_take), .res_valid(res_valid),
    .res_ch0(res_ch0), .res_ch1(res_ch1), .int_raise(int_raise),
    .rd_data(rd_data), .int_pending(int_pending), .int_clr(int_clr),
    .ptr_q(ptr_q), .incr_q(incr_q), .ptr_step(ptr_step),
    .enable_o(enable_o), .atime_o(atime_o), .wtime_o(wtime_o),
    .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o), .pers_o(pers_o),
    .config_o(config_o), .control_o(control_o)
  );

endmodule

// File: rtl/i2c_cmd_regif_chk.sv
module i2c_cmd_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       int_raise,
  input logic       int_pending,
  input logic       int_clr,
  input logic       ptr_step,
  input logic       incr_q,
  input logic [4:0] ptr_q
);

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R2

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R12

  AST_INT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    int_raise |=> int_pending); // R11

  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !int_raise) |=> !int_pending); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && incr_q && ptr_q == 5'h1F) |=> (ptr_q == 5'h00)); // R9

endmodule

bind i2c_cmd_regif i2c_cmd_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .int_raise(int_raise),
  .int_pending(int_pending), .int_clr(int_clr), .ptr_step(ptr_step),
  .incr_q(incr_q), .ptr_q(ptr_q)
);

// File: tb/i2c_cmd_regif_test.sv
module i2c_cmd_regif_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] AW = 8'h72;
  localparam logic [7:0] AR = 8'h73;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [15:0] res_ch0 = '0;
  logic [15:0] res_ch1 = '0;
  logic        int_raise = 1'b0;
  logic        int_pending;
  logic [7:0]  enable_o, atime_o, wtime_o, pers_o, config_o, control_o;
  logic [15:0] thr_lo_o, thr_hi_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_regif uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .res_valid(res_valid), .res_ready(res_ready), .res_ch0(res_ch0),
    .res_ch1(res_ch1), .int_raise(int_raise), .int_pending(int_pending),
    .enable_o(enable_o), .atime_o(atime_o), .wtime_o(wtime_o),
    .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o), .pers_o(pers_o),
    .config_o(config_o), .control_o(control_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; waitc(HALF);
    sda_m = 1'b0; waitc(HALF);
    scl_m = 1'b0; waitc(HALF);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; waitc(HALF);
    scl_m = 1'b1; waitc(HALF);
    sda_m = 1'b0; waitc(HALF);
    scl_m = 1'b0; waitc(HALF);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitc(HALF);
    scl_m = 1'b1; waitc(HALF);
    sda_m = 1'b1; waitc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(HALF);
      scl_m = 1'b1; waitc(HALF);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; waitc(HALF);
    scl_m = 1'b1; waitc(HALF/2);
    ack = sda_bus;
    waitc(HALF/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF);
      scl_m = 1'b1; waitc(HALF/2);
      d[i] = sda_bus;
      waitc(HALF/2);
      scl_m = 1'b0;
    end
    sda_m = last; waitc(HALF);
    scl_m = 1'b1; waitc(HALF);
    scl_m = 1'b0; waitc(2);
    sda_m = 1'b1;
  endtask

  task automatic wr2(input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    i2c_start(); send_byte(AW, a); send_byte(cmd, a); send_byte(d, a); i2c_stop();
  endtask

  task automatic cmd_only(input logic [7:0] cmd);
    logic a;
    i2c_start(); send_byte(AW, a); send_byte(cmd, a); i2c_stop();
  endtask

  task automatic cmd_read1(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    i2c_start(); send_byte(AW, a); send_byte(cmd, a);
    i2c_rstart(); send_byte(AR, a); recv_byte(1'b1, d); i2c_stop();
  endtask

  task automatic plain_read1(output logic [7:0] d);
    logic a;
    i2c_start(); send_byte(AR, a); recv_byte(1'b1, d); i2c_stop();
  endtask

  task automatic push_result(input logic [15:0] c0, input logic [15:0] c1);
    res_ch0 = c0; res_ch1 = c1; res_valid = 1'b1;
    waitc(1);
    res_valid = 1'b0;
    waitc(2);
  endtask

  task automatic t_reset();
    check("R6 enable reset", enable_o, 8'h00);
    check("R6 atime reset", atime_o, 8'hFF);
    check("R6 wtime reset", wtime_o, 8'hFF);
    check("R6 thresholds reset", {thr_hi_o, thr_lo_o}, 32'h0);
    check("R6 pers/config/control reset", {pers_o, config_o, control_o}, 24'h0);
    check("R11 int_pending reset", int_pending, 1'b0);
    check("R12 sda released at reset", sda_oe, 1'b0);
    check("R10 res_ready high", res_ready, 1'b1);
  endtask

  task automatic t_address();
    logic a;
    i2c_start(); send_byte(8'h52, a);
    check("R1 foreign address NACK", a, 1'b1);
    send_byte(8'h00, a);
    check("R1 no ack after foreign address", a, 1'b1);
    i2c_stop();
    i2c_start(); send_byte(AW, a);
    check("R1 R12 own address ACK pulls SDA low", a, 1'b0);
    i2c_stop(); waitc(2);
    check("R2 SDA released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_write_modes();
    logic a;
    wr2(8'h80, 8'h13);
    check("R5 data byte stored at ENABLE", enable_o, 8'h13);
    i2c_start(); send_byte(AW, a); send_byte(8'h81, a);
    send_byte(8'h11, a); send_byte(8'h22, a); i2c_stop();
    check("R3 repeat mode last byte in ATIME", atime_o, 8'h22);
    check("R3 repeat mode leaves WTIME", wtime_o, 8'hFF);
    i2c_start(); send_byte(AW, a); send_byte(8'hA4, a);
    send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h03, a); send_byte(8'h04, a); i2c_stop();
    check("R3 increment low threshold", thr_lo_o, 16'h0201);
    check("R3 increment high threshold", thr_hi_o, 16'h0403);
  endtask

  task automatic t_read_paths();
    logic [7:0] d;
    logic a;
    wr2(8'h8F, 8'h02);
    check("R5 control written", control_o, 8'h02);
    plain_read1(d);
    check("R5 read without command uses stored pointer", d, 8'h02);
    i2c_start(); send_byte(AW, a); send_byte(8'h92, a); send_byte(8'h55, a);
    i2c_rstart(); send_byte(AR, a); recv_byte(1'b1, d); i2c_stop();
    check("R7 R2 ID ignores write, read after repeated start", d, 8'h04);
    cmd_read1(8'h82, d);
    check("R7 unimplemented reads zero", d, 8'h00);
    i2c_start(); send_byte(AW, a); send_byte(8'hB2, a);
    i2c_rstart(); send_byte(AR, a); recv_byte(1'b0, d);
    check("R3 increment read ID", d, 8'h04);
    recv_byte(1'b1, d); i2c_stop();
    check("R6 status reset value", d, 8'h00);
  endtask

  task automatic t_shadow();
    logic [7:0] d;
    logic [7:0] b [4];
    logic a;
    push_result(16'h1234, 16'hABCD);
    i2c_start(); send_byte(AW, a); send_byte(8'hB4, a);
    i2c_rstart(); send_byte(AR, a);
    for (int i = 0; i < 4; i++) recv_byte(i == 3, b[i]);
    i2c_stop();
    check("R10 ch0 low", b[0], 8'h34);
    check("R8 ch0 high via shadow", b[1], 8'h12);
    check("R10 ch1 low", b[2], 8'hCD);
    check("R8 ch1 high via shadow", b[3], 8'hAB);
    cmd_read1(8'h94, d);
    check("R8 low byte before new result", d, 8'h34);
    push_result(16'h5678, 16'h0000);
    cmd_read1(8'h95, d);
    check("R8 shadow holds old high byte", d, 8'h12);
    cmd_read1(8'h94, d);
    check("R10 new low byte captured", d, 8'h78);
  endtask

  task automatic t_interrupt();
    logic [7:0] d;
    int_raise = 1'b1; waitc(1); int_raise = 1'b0; waitc(1);
    check("R11 raise sets pending", int_pending, 1'b1);
    cmd_read1(8'h93, d);
    check("R11 status shows pending and valid", d, 8'h11);
    cmd_only(8'hE0);
    check("R4 no-op special keeps pending", int_pending, 1'b1);
    cmd_only(8'hC0);
    check("R4 reserved type keeps pending", int_pending, 1'b1);
    plain_read1(d);
    check("R4 reserved type keeps pointer", d, 8'h11);
    cmd_only(8'hE6);
    check("R4 clear special drops pending", int_pending, 1'b0);
    plain_read1(d);
    check("R4 clear special keeps pointer", d, 8'h01);
  endtask

  task automatic t_wrap();
    logic a;
    i2c_start(); send_byte(AW, a); send_byte(8'hBF, a);
    send_byte(8'h77, a); send_byte(8'h05, a); i2c_stop();
    check("R9 pointer wraps 0x1F to 0x00", enable_o, 8'h05);
    check("R7 write to 0x1F ignored", atime_o, 8'h22);
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_address();
    t_write_modes();
    t_read_paths();
    t_shadow();
    t_interrupt();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule